// File: doc/BRIEF.md
# Four-to-Six Octet Dual-Clock Gearbox

This block sits on the receive side of a serial link, between the lane logic and the transport layer. It accepts 4 octets per beat on the link clock and produces 6 octets per beat on a device clock that runs at two thirds of the link clock frequency. Three input beats carry the octets of two output beats. Every output beat starts on a frame boundary and holds a whole number of frames: two 3-octet frames, or one 6-octet frame.

Octets are collected in a dual-clock buffer of 12-octet groups, since 12 is the smallest common multiple of the two widths. Only group counts cross between the clocks, as Gray codes. The writer starts at the first input beat that is flagged as the multiframe start. The reader starts at a device-domain sync pulse once enough groups are known to be written, so the latency after every reset is fixed. Sticky flags report a fill level that leaves its expected range, which means the two clocks are not in the assumed ratio.

Both sides run at a fixed rate. Neither side has a ready signal, so the link side cannot be stalled and the device side must take every beat it is given. When both widths are set equal, the block becomes a plain wire-through.

Top module: `octet_gearbox`

## Requirements
- R1: Octet order is kept. In both `in_data` and `out_data`, octet i sits at bits [8i+7:8i]. Octet 0 of the first accepted input beat is octet 0 of the first output beat, and the octet stream that comes out equals the accepted stream with no octet lost or repeated.
- R2: After reset, `out_valid` stays 0 until reading starts. From then on it is 1 on every device cycle until the next reset.
- R3: On every beat where `out_valid` is 1, `out_frame_start` is 6'b001001 when `frame_sel`=0 (3-octet frames) and 6'b000001 when `frame_sel`=1 (6-octet frames). It is 0 whenever `out_valid` is 0.
- R4: Reading starts only on a device clock edge where `dev_sync` is sampled 1 and at least two complete groups are known to be written. The first valid output beat appears on that edge.
- R5: Input beats that arrive before the first beat with `in_sof`=1 are dropped and never appear at the output.
- R6: Once the writer is aligned, a later `in_sof` has no effect on the octet stream.
- R7: If more than 16 groups are written ahead of the reader, `wr_overflow` goes to 1 and stays 1 until reset.
- R8: If the reader starts a group that is not known to be written, `rd_underflow` goes to 1 and stays 1 until reset.
- R9: A reset on either side clears both sides: `out_valid` and both flags go to 0, and the writer waits for a new `in_sof` before it accepts data again.
- R10: With `IN_OCTETS` equal to `OUT_OCTETS`, `out_data` equals `in_data` and `out_valid` equals `in_valid` in the same cycle.
- R11: `dev_sync` pulses that arrive after reading has started have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link-side clock |
| link_rst_n | input | 1 | Link-side synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | Input beat starts a multiframe |
| in_data | input | IN_OCTETS*8 | Input octets, octet 0 in the low bits |
| dev_clk | input | 1 | Device-side clock |
| dev_rst_n | input | 1 | Device-side synchronous reset, active low |
| dev_sync | input | 1 | Device-domain alignment pulse |
| frame_sel | input | 1 | 0: 3-octet frames, 1: 6-octet frames |
| out_valid | output | 1 | Output beat present |
| out_data | output | OUT_OCTETS*8 | Output octets, octet 0 in the low bits |
| out_frame_start | output | OUT_OCTETS | Octet positions where a frame begins |
| wr_overflow | output | 1 | Sticky: writer ran too far ahead |
| rd_underflow | output | 1 | Sticky: reader caught up with writer |

## Verification
The assertions check on every cycle the things that hold locally. Each crossing Gray count moves by at most one bit per step. `out_valid` never drops once it has risen, and its rise follows a sampled sync pulse. The frame-start marks track `out_valid`. Both fault flags are sticky. The writer stays at its origin until `in_sof` arrives. The bench scenarios cover what only shows end to end across the two clocks: that the octet stream is preserved through the 4-to-6 resize under different lead-in junk, seeds and repeated `in_sof` pulses, that the flags rise under a stalled reader or a starved writer, that a reset on one side clears the other, and that the equal-width build is a pure pass-through.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;

  typedef enum logic {RD_WAIT, RD_RUN} rd_state_e;

  function automatic int gcd(input int a, input int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = y;
      y = x % y;
      x = t;
    end
    return x;
  endfunction

  function automatic int lcm(input int a, input int b);
    return (a / gcd(a, b)) * b;
  endfunction

  // Bit p set where a frame begins at octet position p of a beat.
  function automatic logic [63:0] frame_marks(input int width, input logic six);
    int fs = six ? 6 : 3;
    logic [63:0] m = '0;
    for (int p = 0; p < width && p < 64; p++) begin
      if (p % fs == 0) m[p] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gbx_gray_sync.sv
`timescale 1ns/1ps
module gbx_gray_sync #(
  parameter int W = 5
) (
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic [W-1:0] src_gray,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge dst_clk) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    dst_bin[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/gbx_octet_ram.sv
`timescale 1ns/1ps
module gbx_octet_ram #(
  parameter int IN_OCTETS  = 4,
  parameter int OUT_OCTETS = 6,
  parameter int DEPTH      = 192,
  parameter int AW         = 8
) (
  input  logic                    wclk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [IN_OCTETS*8-1:0]  wdata,
  input  logic [AW-1:0]           raddr,
  output logic [OUT_OCTETS*8-1:0] rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      for (int i = 0; i < IN_OCTETS; i++) mem[AW'(int'(waddr) + i)] <= wdata[8*i +: 8];
    end
  end

  for (genvar g = 0; g < OUT_OCTETS; g++) begin : g_rd
    assign rdata[8*g +: 8] = mem[AW'(int'(raddr) + g)];
  end
endmodule

// File: rtl/gbx_wr_ctrl.sv
`timescale 1ns/1ps
module gbx_wr_ctrl #(
  parameter int IN_OCTETS    = 4,
  parameter int GROUP_OCTETS = 12,
  parameter int GROUPS       = 16,
  parameter int GW           = 5,
  parameter int AW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [GW-1:0] rd_grp_bin,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [GW-1:0] wr_grp_gray,
  output logic          overflow
);
  localparam int BEATS = GROUP_OCTETS / IN_OCTETS;
  localparam int PW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic          aligned;
  logic [PW-1:0] phase;
  logic [GW-1:0] grp_bin, grp_next, fill_next;

  assign we        = in_valid && (aligned || in_sof);
  assign grp_next  = grp_bin + 1'b1;
  assign fill_next = grp_next - rd_grp_bin;
  assign waddr     = AW'(int'(grp_bin[GW-2:0]) * GROUP_OCTETS + int'(phase) * IN_OCTETS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned     <= 1'b0;
      phase       <= '0;
      grp_bin     <= '0;
      wr_grp_gray <= '0;
      overflow    <= 1'b0;
    end else if (we) begin
      aligned <= 1'b1;
      if (int'(phase) == BEATS - 1) begin
        phase       <= '0;
        grp_bin     <= grp_next;
        wr_grp_gray <= grp_next ^ (grp_next >> 1);
        if (int'(fill_next) > GROUPS) overflow <= 1'b1;
      end else begin
        phase <= PW'(phase + 1'b1);
      end
    end
  end

  // R5: before alignment, beats without a multiframe start leave the writer at its origin
  assert_wait_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned && !in_sof) |=> (grp_bin == '0 && phase == '0));
  // R1: the crossing count changes by at most one bit per step
  assert_wr_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_grp_gray ^ $past(wr_grp_gray)) <= 1);
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/gbx_rd_ctrl.sv
`timescale 1ns/1ps
module gbx_rd_ctrl #(
  parameter int OUT_OCTETS   = 6,
  parameter int GROUP_OCTETS = 12,
  parameter int GW           = 5,
  parameter int AW           = 8,
  parameter int START_GROUPS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dev_sync,
  input  logic                    frame_sel,
  input  logic [GW-1:0]           wr_grp_bin,
  input  logic [OUT_OCTETS*8-1:0] rdata,
  output logic [AW-1:0]           raddr,
  output logic [GW-1:0]           rd_grp_gray,
  output logic                    out_valid,
  output logic [OUT_OCTETS*8-1:0] out_data,
  output logic [OUT_OCTETS-1:0]   out_frame_start,
  output logic                    underflow
);
  import gbx_pkg::*;

  localparam int BEATS = GROUP_OCTETS / OUT_OCTETS;
  localparam int PW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  rd_state_e     state;
  logic [PW-1:0] phase;
  logic [GW-1:0] grp_bin, grp_next, avail;
  logic          go;

  assign avail    = wr_grp_bin - grp_bin;
  assign grp_next = grp_bin + 1'b1;
  assign go       = (state == RD_RUN) || (dev_sync && int'(avail) >= START_GROUPS);
  assign raddr    = AW'(int'(grp_bin[GW-2:0]) * GROUP_OCTETS + int'(phase) * OUT_OCTETS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= RD_WAIT;
      phase           <= '0;
      grp_bin         <= '0;
      rd_grp_gray     <= '0;
      out_valid       <= 1'b0;
      out_data        <= '0;
      out_frame_start <= '0;
      underflow       <= 1'b0;
    end else begin
      out_valid <= go;
      if (go) begin
        state           <= RD_RUN;
        out_data        <= rdata;
        out_frame_start <= OUT_OCTETS'(frame_marks(OUT_OCTETS, frame_sel));
        if (phase == '0 && avail == '0) underflow <= 1'b1;
        if (int'(phase) == BEATS - 1) begin
          phase       <= '0;
          grp_bin     <= grp_next;
          rd_grp_gray <= grp_next ^ (grp_next >> 1);
        end else begin
          phase <= PW'(phase + 1'b1);
        end
      end else begin
        out_frame_start <= '0;
      end
    end
  end

  assert_valid_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  assert_start_on_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(dev_sync));
  assert_frame_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid ? out_frame_start[0] : (out_frame_start == '0));
  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  assert_rd_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_grp_gray ^ $past(rd_grp_gray)) <= 1);
endmodule

// File: rtl/octet_gearbox.sv
`timescale 1ns/1ps
module octet_gearbox #(
  parameter int IN_OCTETS    = 4,
  parameter int OUT_OCTETS   = 6,
  parameter int GROUPS       = 16,
  parameter int START_GROUPS = 2
) (
  input  logic                    link_clk,
  input  logic                    link_rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [IN_OCTETS*8-1:0]  in_data,
  input  logic                    dev_clk,
  input  logic                    dev_rst_n,
  input  logic                    dev_sync,
  input  logic                    frame_sel,
  output logic                    out_valid,
  output logic [OUT_OCTETS*8-1:0] out_data,
  output logic [OUT_OCTETS-1:0]   out_frame_start,
  output logic                    wr_overflow,
  output logic                    rd_underflow
);
  localparam int GROUP_OCTETS = gbx_pkg::lcm(IN_OCTETS, OUT_OCTETS);
  localparam int DEPTH        = GROUPS * GROUP_OCTETS;
  localparam int AW           = $clog2(DEPTH);
  localparam int GW           = $clog2(GROUPS) + 1;

  if (IN_OCTETS == OUT_OCTETS) begin : g_bypass
    assign out_data        = in_data;
    assign out_valid       = in_valid;
    assign out_frame_start = in_valid ? OUT_OCTETS'(gbx_pkg::frame_marks(OUT_OCTETS, frame_sel)) : '0;
    assign wr_overflow     = 1'b0;
    assign rd_underflow    = 1'b0;
  end else begin : g_gear
    logic [1:0]    dev_rst_at_link, link_rst_at_dev;
    logic          wr_rst_n, rd_rst_n, we;
    logic [AW-1:0] waddr, raddr;
    logic [GW-1:0] wr_gray, rd_gray, wr_bin_dev, rd_bin_link;
    logic [OUT_OCTETS*8-1:0] rdata;

    // Either reset clears both sides.
    always_ff @(posedge link_clk) dev_rst_at_link <= {dev_rst_at_link[0], dev_rst_n};
    always_ff @(posedge dev_clk)  link_rst_at_dev <= {link_rst_at_dev[0], link_rst_n};
    assign wr_rst_n = link_rst_n & dev_rst_at_link[1];
    assign rd_rst_n = dev_rst_n & link_rst_at_dev[1];

    gbx_wr_ctrl #(.IN_OCTETS(IN_OCTETS), .GROUP_OCTETS(GROUP_OCTETS), .GROUPS(GROUPS),
                  .GW(GW), .AW(AW)) wr_i (
      .clk(link_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .rd_grp_bin(rd_bin_link), .we(we), .waddr(waddr), .wr_grp_gray(wr_gray),
      .overflow(wr_overflow));

    gbx_octet_ram #(.IN_OCTETS(IN_OCTETS), .OUT_OCTETS(OUT_OCTETS), .DEPTH(DEPTH),
                    .AW(AW)) ram_i (
      .wclk(link_clk), .we(we), .waddr(waddr), .wdata(in_data), .raddr(raddr),
      .rdata(rdata));

    gbx_gray_sync #(.W(GW)) w2r_i (
      .dst_clk(dev_clk), .dst_rst_n(rd_rst_n), .src_gray(wr_gray), .dst_bin(wr_bin_dev));

    gbx_gray_sync #(.W(GW)) r2w_i (
      .dst_clk(link_clk), .dst_rst_n(wr_rst_n), .src_gray(rd_gray), .dst_bin(rd_bin_link));

    gbx_rd_ctrl #(.OUT_OCTETS(OUT_OCTETS), .GROUP_OCTETS(GROUP_OCTETS), .GW(GW), .AW(AW),
                  .START_GROUPS(START_GROUPS)) rd_i (
      .clk(dev_clk), .rst_n(rd_rst_n), .dev_sync(dev_sync), .frame_sel(frame_sel),
      .wr_grp_bin(wr_bin_dev), .rdata(rdata), .raddr(raddr), .rd_grp_gray(rd_gray),
      .out_valid(out_valid), .out_data(out_data), .out_frame_start(out_frame_start),
      .underflow(rd_underflow));
  end
endmodule

// File: tb/octet_gearbox_tb_top.sv
`timescale 1ns/1ps
module octet_gearbox_tb_top;
  localparam int  LINK_PERIOD = 10;
  localparam real DEV_HALF    = LINK_PERIOD * 0.75;
  localparam int  NOCT        = 60;

  // Table: [23:18] expected frame marks, [17] frame_sel, [16:13] junk beats before sof,
  // [12] extra sof mid-stream, [7:0] first octet value.
  localparam int NVEC = 4;
  localparam logic [23:0] VECS [NVEC] = '{
    {6'b001001, 1'b0, 4'd0, 1'b0, 4'h0, 8'h10},
    {6'b000001, 1'b1, 4'd3, 1'b1, 4'h0, 8'h80},
    {6'b001001, 1'b0, 4'd5, 1'b1, 4'h0, 8'hF0},
    {6'b000001, 1'b1, 4'd1, 1'b0, 4'h0, 8'h33}
  };

  logic link_clk = 1'b0, dev_clk = 1'b0;
  logic link_rst_n = 1'b0, dev_rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, dev_sync = 1'b0, frame_sel = 1'b0;
  logic [31:0] in_data = '0;
  logic out_valid, wr_overflow, rd_underflow;
  logic [47:0] out_data;
  logic [5:0]  out_frame_start;

  logic bp_valid = 1'b0;
  logic [31:0] bp_data = '0;
  logic bp_out_valid, bp_ovf, bp_unf;
  logic [31:0] bp_out_data;
  logic [3:0]  bp_fs;

  int n_checks = 0, n_err = 0;
  bit feed_on = 0, sof_again = 0, sync_en = 0;
  int junk_left = 0, oct_k = 0;
  logic [7:0] seed = 8'h00;
  logic [5:0] exp_mask = '0;

  logic [7:0] got [512];
  int  got_n = 0, gaps = 0, fs_err = 0;
  bit  mon_started = 0;
  logic mon_first_sync = 1'b0;

  initial forever #(LINK_PERIOD / 2.0) link_clk = ~link_clk;
  initial forever #(DEV_HALF) dev_clk = ~dev_clk;

  octet_gearbox dut_i (
    .link_clk(link_clk), .link_rst_n(link_rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .dev_clk(dev_clk), .dev_rst_n(dev_rst_n), .dev_sync(dev_sync),
    .frame_sel(frame_sel), .out_valid(out_valid), .out_data(out_data),
    .out_frame_start(out_frame_start), .wr_overflow(wr_overflow), .rd_underflow(rd_underflow));

  octet_gearbox #(.IN_OCTETS(4), .OUT_OCTETS(4)) byp_i (
    .link_clk(link_clk), .link_rst_n(link_rst_n), .in_valid(bp_valid), .in_sof(1'b0),
    .in_data(bp_data), .dev_clk(link_clk), .dev_rst_n(link_rst_n), .dev_sync(1'b0),
    .frame_sel(frame_sel), .out_valid(bp_out_valid), .out_data(bp_out_data),
    .out_frame_start(bp_fs), .wr_overflow(bp_ovf), .rd_underflow(bp_unf));

  // Link-side feeder: junk beats, then a counting octet stream starting with sof.
  initial forever begin
    @(negedge link_clk);
    if (!feed_on) begin
      in_valid = 1'b0; in_sof = 1'b0;
    end else if (junk_left > 0) begin
      in_valid = 1'b1; in_sof = 1'b0; in_data = {4{8'hEE}}; junk_left--;
    end else begin
      in_valid = 1'b1;
      in_sof = (oct_k == 0) || (sof_again && oct_k == 48);
      for (int i = 0; i < 4; i++) in_data[8*i +: 8] = 8'(int'(seed) + oct_k + i);
      oct_k += 4;
    end
  end

  // Device-side sync pulse every fourth cycle.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge dev_clk);
      dev_sync = sync_en && (cnt % 4 == 0);
      cnt++;
    end
  end

  // Output monitor.
  initial begin
    logic cap;
    forever begin
      @(posedge dev_clk);
      cap = dev_sync;
      @(negedge dev_clk);
      if (out_valid) begin
        if (!mon_started) begin mon_started = 1; mon_first_sync = cap; end
        for (int i = 0; i < 6; i++) if (got_n < 500) begin got[got_n] = out_data[8*i +: 8]; got_n++; end
        if (out_frame_start != exp_mask) fs_err++;
      end else if (mon_started) begin
        gaps++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic mon_clear();
    got_n = 0; gaps = 0; fs_err = 0; mon_started = 0; mon_first_sync = 1'b0;
  endtask

  task automatic reset_all();
    @(posedge link_clk);
    feed_on = 0; sync_en = 0; link_rst_n = 1'b0; dev_rst_n = 1'b0;
    repeat (8) @(posedge link_clk);
    link_rst_n = 1'b1; dev_rst_n = 1'b1;
    repeat (6) @(posedge link_clk);
    mon_clear();
  endtask

  task automatic start_stream(input logic [7:0] s, input int junk, input bit again);
    @(posedge link_clk);
    seed = s; junk_left = junk; sof_again = again; oct_k = 0; feed_on = 1; sync_en = 1;
  endtask

  task automatic wait_octets(input int n);
    for (int t = 0; t < 400 && got_n < n; t++) @(negedge dev_clk);
  endtask

  task automatic check_stream(input logic [7:0] s, input int n, input string req);
    int bad = 0;
    logic [7:0] fa = '0, fe = '0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = 8'(int'(s) + k);
      if (k >= got_n || got[k] !== e) begin
        if (bad == 0) begin fa = (k < got_n) ? got[k] : 8'hXX; fe = e; end
        bad++;
      end
    end
    check(bad == 0, req, fa, fe);
  endtask

  initial begin
    #(LINK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_sim();
  end

  initial begin
    // Reset state (R9, R2).
    repeat (4) @(posedge link_clk);
    @(negedge dev_clk);
    check(out_valid == 1'b0, "R2 out_valid low in reset", out_valid, 0);
    check({wr_overflow, rd_underflow} == 2'b00, "R9 flags clear in reset", {wr_overflow, rd_underflow}, 0);

    // Table-driven streams (R1, R3, R4, R5, R6, R11, R2).
    for (int v = 0; v < NVEC; v++) begin
      reset_all();
      frame_sel = VECS[v][17];
      exp_mask  = VECS[v][23:18];
      start_stream(VECS[v][7:0], int'(VECS[v][16:13]), VECS[v][12]);
      wait_octets(NOCT);
      check_stream(VECS[v][7:0], NOCT, $sformatf("R1 R5 R6 R11 octet stream vec%0d", v));
      check(fs_err == 0, $sformatf("R3 frame marks vec%0d", v), fs_err, 0);
      check(mon_first_sync == 1'b1, $sformatf("R4 start on sync vec%0d", v), mon_first_sync, 1);
      check(gaps == 0, $sformatf("R2 no gap after start vec%0d", v), gaps, 0);
      check({wr_overflow, rd_underflow} == 2'b00, $sformatf("R7 R8 no flags in steady run vec%0d", v),
            {wr_overflow, rd_underflow}, 0);
    end

    // Reader never released: overflow (R7) and no output (R2).
    reset_all();
    start_stream(8'h01, 0, 0);
    @(posedge link_clk); sync_en = 0;
    repeat (80) @(posedge link_clk);
    @(negedge dev_clk);
    check(wr_overflow == 1'b1, "R7 overflow with stalled reader", wr_overflow, 1);
    check(out_valid == 1'b0, "R2 no output without sync", out_valid, 0);
    repeat (20) @(posedge link_clk);
    @(negedge dev_clk);
    check(wr_overflow == 1'b1, "R7 overflow sticky", wr_overflow, 1);

    // Writer starved while reading: underflow (R8).
    reset_all();
    start_stream(8'h40, 0, 0);
    wait_octets(24);
    @(posedge link_clk); feed_on = 0;
    repeat (40) @(negedge dev_clk);
    check(rd_underflow == 1'b1, "R8 underflow with starved writer", rd_underflow, 1);
    repeat (10) @(negedge dev_clk);
    check(rd_underflow == 1'b1, "R8 underflow sticky", rd_underflow, 1);

    // Device-side reset mid-run clears both sides (R9).
    reset_all();
    start_stream(8'h55, 0, 0);
    wait_octets(30);
    @(posedge link_clk); dev_rst_n = 1'b0;
    repeat (6) @(posedge link_clk);
    dev_rst_n = 1'b1;
    repeat (2) @(negedge dev_clk);
    check(out_valid == 1'b0 && rd_underflow == 1'b0, "R9 dev reset clears output",
          {out_valid, rd_underflow}, 0);
    repeat (40) @(negedge dev_clk);
    check(out_valid == 1'b0, "R9 writer waits for new sof", out_valid, 0);
    mon_clear();
    @(posedge link_clk); oct_k = 0; seed = 8'hA0;
    wait_octets(30);
    check_stream(8'hA0, 30, "R9 realign after dev reset");

    // Link-side reset mid-run clears the reader (R9).
    @(posedge link_clk);
    link_rst_n = 1'b0;
    repeat (6) @(posedge link_clk);
    link_rst_n = 1'b1;
    repeat (3) @(negedge dev_clk);
    check(out_valid == 1'b0, "R9 link reset clears reader", out_valid, 0);

    // Equal-width pass-through (R10).
    @(negedge link_clk); bp_valid = 1'b1; bp_data = 32'hDEADBEEF;
    #1;
    check(bp_out_data == 32'hDEADBEEF, "R10 bypass data", bp_out_data, 32'hDEADBEEF);
    check(bp_out_valid == 1'b1, "R10 bypass valid", bp_out_valid, 1);
    @(negedge link_clk); bp_valid = 1'b0; bp_data = 32'h01234567;
    #1;
    check(bp_out_valid == 1'b0 && bp_out_data == 32'h01234567, "R10 bypass idle",
          {bp_out_valid, bp_out_data}, {1'b0, 32'h01234567});

    finish_sim();
  end
endmodule